// File: doc/BRIEF.md
# Two-Sided Mailbox Buffer with Ownership Handshake

This block is a small shared buffer of fifteen byte cells that sits between an external host processor (the "master") and a local processor (the "slave"). A message moves in one direction at a time. Whichever side writes cell 0 first takes the buffer and shuts the other side out of writing. Writing cell 14 tells the receiver that the message is complete. The receiver hands the buffer back by reading cell 14 first and cell 0 last. These accesses set and clear a set of handshake flags.

Both sides have an address, write data, read data, a read strobe and a write strobe. Strobes take effect on the rising clock edge. Read data is combinational from the current contents. On the slave side, address 15 selects a status/control byte that holds the flags and two enable bits. The master is told about a finished message or a completed receipt through an active-low ready line. The slave is told that the master has finished reading through an interrupt request.

Top module: `mbx_mailbox`

## Requirements
- R1: After reset, every cell reads 0, the status byte reads 8'h00, `ready_n` is 1 and `irq` is 0.
- R2: An accepted write to cell k (0..14) is returned by both read ports at cell k from the next cycle on. If both sides write the same cell in one cycle, the master's data is kept.
- R3: A slave write to cell 0 while master-write mode is clear sets slave-write mode (status bit 0).
- R4: While slave-write mode is set, every master write is dropped: the cell contents are unchanged and master-write mode is not set.
- R5: A slave write to cell 14 sets the slave-write-end flag (status bit 2). If the ack enable (status bit 6) is 1, `ready_n` is 0 from the next cycle.
- R6: A master read of cell 14 clears slave-write-end. A master read of cell 0 while slave-write mode is set clears slave-write mode and sets the master-read-end flag (status bit 4).
- R7: `irq` is 1 exactly when master-read-end and the interrupt enable (status bit 7) are both 1.
- R8: A master write to cell 0 while slave-write mode is clear sets master-write mode (status bit 1). While that mode is set, every slave write to cells 0..14 is dropped.
- R9: A master write to cell 14 sets the master-write-end flag (status bit 3). A slave read of cell 14 clears it.
- R10: A slave read of cell 0 while master-write mode is set clears that mode. If the ack enable is 1, `ready_n` is 0 from the next cycle.
- R11: Once low, `ready_n` stays low until a cycle with a master read or write strobe, and returns to 1 after that edge.
- R12: If both sides write cell 0 in the same cycle with neither mode set, the master wins: only master-write mode is set and cell 0 holds the master's byte.
- R13: A slave write to address 15 loads bits 6 and 7. It clears master-read-end when bit 4 is 0 and leaves it alone when bit 4 is 1. Bits 0 to 3 are never changed by it.
- R14: With the ack enable at 0, `ready_n` never goes low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| m_addr | input | 4 | Master cell address (0..14) |
| m_wdata | input | 8 | Master write data |
| m_wr | input | 1 | Master write strobe |
| m_rd | input | 1 | Master read strobe |
| m_rdata | output | 8 | Master read data (combinational) |
| s_addr | input | 4 | Slave address: 0..14 cells, 15 status byte |
| s_wdata | input | 8 | Slave write data |
| s_wr | input | 1 | Slave write strobe |
| s_rd | input | 1 | Slave read strobe |
| s_rdata | output | 8 | Slave read data (combinational) |
| ready_n | output | 1 | Active-low completion/acknowledge line to master |
| irq | output | 1 | Master-read-end interrupt request to slave |

## Verification
Some properties are checked on every clock. The two write modes are never set together. Writes from the locked-out side never reach the cell array. The slave mode and the read-end flag only rise after the right strobe. `ready_n` only falls with the ack enable set, and it is released by a master access. `irq` never shows without the read-end flag. The bench's directed sequences are needed for the rest. These cover the full transfer in each direction with the cell contents read back, the same-cycle claim race, the masking of status-byte writes, and disabled acknowledge and interrupt. A behavioural model compared every cycle backs up these sequences.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
  localparam int DW = 8;

  typedef struct packed {
    logic ien;
    logic ack_en;
    logic mre;
    logic mwe;
    logic swe;
    logic mwm;
    logic swm;
  } mbx_state_t;

  // Status byte image: bit0 swm, bit1 mwm, bit2 swe, bit3 mwe, bit4 mre,
  // bit5 zero, bit6 ack enable, bit7 interrupt enable.
  function automatic logic [DW-1:0] csr_image(mbx_state_t st);
    logic [DW-1:0] v;
    v    = '0;
    v[0] = st.swm;
    v[1] = st.mwm;
    v[2] = st.swe;
    v[3] = st.mwe;
    v[4] = st.mre;
    v[6] = st.ack_en;
    v[7] = st.ien;
    return v;
  endfunction

  // Next value of a flag with set priority over clear.
  function automatic logic set_clr(logic cur, logic set, logic clr);
    return set ? 1'b1 : (clr ? 1'b0 : cur);
  endfunction
endpackage

// File: rtl/mbx_storage.sv
module mbx_storage
  import mbx_pkg::*;
#(
  parameter int NBYTES = 15,
  parameter int AW     = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          m_we,
  input  logic [AW-1:0] m_addr,
  input  logic [DW-1:0] m_wdata,
  input  logic          s_we,
  input  logic [AW-1:0] s_addr,
  input  logic [DW-1:0] s_wdata,
  output logic [DW-1:0] m_rdata,
  output logic [DW-1:0] s_rdata
);
  logic [DW-1:0] cells [NBYTES];
  logic [NBYTES-1:0] sel_m, sel_s, hit_m, hit_s;

  for (genvar i = 0; i < NBYTES; i++) begin : g_dec
    assign hit_m[i] = (m_addr == AW'(i));
    assign hit_s[i] = (s_addr == AW'(i));
    assign sel_m[i] = m_we && hit_m[i];
    assign sel_s[i] = s_we && hit_s[i];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NBYTES; i++) cells[i] <= '0;
    end else begin
      for (int i = 0; i < NBYTES; i++) begin
        if (sel_m[i])      cells[i] <= m_wdata;
        else if (sel_s[i]) cells[i] <= s_wdata;
      end
    end
  end

  always_comb begin
    m_rdata = '0;
    s_rdata = '0;
    for (int i = 0; i < NBYTES; i++) begin
      if (hit_m[i]) m_rdata = cells[i];
      if (hit_s[i]) s_rdata = cells[i];
    end
  end
endmodule

// File: rtl/mbx_flags.sv
module mbx_flags
  import mbx_pkg::*;
#(
  parameter int NBYTES = 15,
  parameter int AW     = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] m_addr,
  input  logic          m_wr,
  input  logic          m_rd,
  input  logic [AW-1:0] s_addr,
  input  logic          s_wr,
  input  logic          s_rd,
  input  logic [2:0]    ctl_bits,   // {ien, ack_en, mre_keep}
  output mbx_state_t    st,
  output logic          m_we,
  output logic          s_we,
  output logic          m_claim,
  output logic          ready_n
);
  localparam logic [AW-1:0] A_CLAIM = '0;
  localparam logic [AW-1:0] A_END   = AW'(NBYTES - 1);
  localparam logic [AW-1:0] A_CSR   = AW'(NBYTES);

  logic m_in, s_in, s_claim, csr_wr;
  logic ev_swe_set, ev_swe_clr, ev_swm_clr;
  logic ev_mwe_set, ev_mwe_clr, ev_mwm_clr;
  logic ev_ack, ev_rdy_rel, ev_mre_clr;

  assign m_in    = (m_addr < A_CSR);
  assign s_in    = (s_addr < A_CSR);
  assign m_claim = m_wr && (m_addr == A_CLAIM) && !st.swm;
  assign m_we    = m_wr && m_in && !st.swm;
  assign s_claim = s_wr && (s_addr == A_CLAIM) && !st.mwm && !m_claim;
  assign s_we    = s_wr && s_in && !st.mwm && !m_claim;
  assign csr_wr  = s_wr && (s_addr == A_CSR);

  assign ev_swe_set = s_we && (s_addr == A_END);
  assign ev_swe_clr = m_rd && (m_addr == A_END);
  assign ev_swm_clr = m_rd && (m_addr == A_CLAIM) && st.swm;
  assign ev_mwe_set = m_we && (m_addr == A_END);
  assign ev_mwe_clr = s_rd && (s_addr == A_END);
  assign ev_mwm_clr = s_rd && (s_addr == A_CLAIM) && st.mwm;
  assign ev_mre_clr = csr_wr && !ctl_bits[0];
  assign ev_ack     = st.ack_en && (ev_swe_set || ev_mwm_clr);
  assign ev_rdy_rel = m_rd || m_wr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= '0;
      ready_n <= 1'b1;
    end else begin
      st.swm  <= set_clr(st.swm, s_claim, ev_swm_clr);
      st.mwm  <= set_clr(st.mwm, m_claim, ev_mwm_clr);
      st.swe  <= set_clr(st.swe, ev_swe_set, ev_swe_clr);
      st.mwe  <= set_clr(st.mwe, ev_mwe_set, ev_mwe_clr);
      st.mre  <= set_clr(st.mre, ev_swm_clr, ev_mre_clr);
      if (csr_wr) begin
        st.ien    <= ctl_bits[2];
        st.ack_en <= ctl_bits[1];
      end
      ready_n <= !set_clr(!ready_n, ev_ack, ev_rdy_rel);
    end
  end
endmodule

// File: rtl/mbx_mailbox.sv
module mbx_mailbox
  import mbx_pkg::*;
#(
  parameter int NBYTES = 15,
  parameter int AW     = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] m_addr,
  input  logic [7:0]    m_wdata,
  input  logic          m_wr,
  input  logic          m_rd,
  output logic [7:0]    m_rdata,
  input  logic [AW-1:0] s_addr,
  input  logic [7:0]    s_wdata,
  input  logic          s_wr,
  input  logic          s_rd,
  output logic [7:0]    s_rdata,
  output logic          ready_n,
  output logic          irq
);
  localparam logic [AW-1:0] A_CSR = AW'(NBYTES);

  mbx_state_t    st;
  logic          m_we, s_we, m_claim;
  logic [2:0]    ctl_bits;
  logic [DW-1:0] s_cell;

  assign ctl_bits = {s_wdata[7], s_wdata[6], s_wdata[4]};

  mbx_flags #(.NBYTES(NBYTES), .AW(AW)) u_flags (
    .clk(clk), .rst_n(rst_n),
    .m_addr(m_addr), .m_wr(m_wr), .m_rd(m_rd),
    .s_addr(s_addr), .s_wr(s_wr), .s_rd(s_rd),
    .ctl_bits(ctl_bits), .st(st),
    .m_we(m_we), .s_we(s_we), .m_claim(m_claim), .ready_n(ready_n)
  );

  mbx_storage #(.NBYTES(NBYTES), .AW(AW)) u_store (
    .clk(clk), .rst_n(rst_n),
    .m_we(m_we), .m_addr(m_addr), .m_wdata(m_wdata),
    .s_we(s_we), .s_addr(s_addr), .s_wdata(s_wdata),
    .m_rdata(m_rdata), .s_rdata(s_cell)
  );

  assign s_rdata = (s_addr == A_CSR) ? csr_image(st) : s_cell;
  assign irq     = st.mre && st.ien;
endmodule

// File: rtl/mbx_checker.sv
module mbx_checker
  import mbx_pkg::*;
#(
  parameter int AW = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic [AW-1:0] m_addr,
  input logic          m_wr,
  input logic          m_rd,
  input logic [AW-1:0] s_addr,
  input logic          s_wr,
  input logic          s_rd,
  input mbx_state_t    st,
  input logic          m_we,
  input logic          s_we,
  input logic          ready_n,
  input logic          irq
);
  p_modes_exclusive_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !(st.swm && st.mwm));

  p_master_locked_r4: assert property (@(posedge clk) disable iff (!rst_n)
    st.swm |-> !m_we);

  p_slave_locked_r8: assert property (@(posedge clk) disable iff (!rst_n)
    st.mwm |-> !s_we);

  p_swm_source_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(st.swm) |-> $past(s_wr && s_addr == '0));

  p_mre_source_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(st.mre) |-> $past(m_rd && m_addr == '0));

  p_ready_needs_ack_r14: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ready_n) |-> $past(st.ack_en));

  p_ready_release_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!ready_n && (m_rd || m_wr) && !s_wr && !s_rd) |=> ready_n);

  p_irq_needs_mre_r7: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (st.mre && st.ien));
endmodule

bind mbx_mailbox mbx_checker #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n),
  .m_addr(m_addr), .m_wr(m_wr), .m_rd(m_rd),
  .s_addr(s_addr), .s_wr(s_wr), .s_rd(s_rd),
  .st(st), .m_we(m_we), .s_we(s_we),
  .ready_n(ready_n), .irq(irq)
);

// File: tb/mbx_mailbox_bench.sv
`timescale 1ns/1ps
module mbx_mailbox_bench;
  logic clk = 0;
  logic rst_n = 0;
  logic [3:0] m_addr = 0, s_addr = 0;
  logic [7:0] m_wdata = 0, s_wdata = 0;
  logic m_wr = 0, m_rd = 0, s_wr = 0, s_rd = 0;
  logic [7:0] m_rdata, s_rdata;
  logic ready_n, irq;

  always #10 clk = ~clk;

  mbx_mailbox u_mbx_mailbox (
    .clk(clk), .rst_n(rst_n),
    .m_addr(m_addr), .m_wdata(m_wdata), .m_wr(m_wr), .m_rd(m_rd), .m_rdata(m_rdata),
    .s_addr(s_addr), .s_wdata(s_wdata), .s_wr(s_wr), .s_rd(s_rd), .s_rdata(s_rdata),
    .ready_n(ready_n), .irq(irq)
  );

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  // behavioural reference
  int  ref_mem [15];
  bit  r_swm, r_mwm, r_swe, r_mwe, r_mre, r_ack, r_ien, r_rdy;
  int  got_m, got_s;

  task automatic check(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic int ref_status();
    return r_swm + 2*r_mwm + 4*r_swe + 8*r_mwe + 16*r_mre + 64*r_ack + 128*r_ien;
  endfunction

  function automatic int ref_read_m(int a);
    if (a < 15) return ref_mem[a];
    return 0;
  endfunction

  function automatic int ref_read_s(int a);
    if (a == 15) return ref_status();
    return ref_mem[a];
  endfunction

  task automatic ref_reset();
    foreach (ref_mem[i]) ref_mem[i] = 0;
    {r_swm, r_mwm, r_swe, r_mwe, r_mre, r_ack, r_ien} = '0;
    r_rdy = 1;
  endtask

  task automatic ref_edge(bit mw, int ma, int md, bit mr, bit sw, int sa, int sd, bit sr);
    bit master_takes, master_ok, slave_ok, ack_now;
    bit n_swm, n_mwm, n_swe, n_mwe, n_mre, n_rdy;
    master_takes = mw && ma == 0 && !r_swm;
    master_ok    = mw && ma < 15 && !r_swm;
    slave_ok     = sw && sa < 15 && !r_mwm && !master_takes;
    n_swm = r_swm; n_mwm = r_mwm; n_swe = r_swe; n_mwe = r_mwe; n_mre = r_mre; n_rdy = r_rdy;
    ack_now = 0;
    if (mr && ma == 14) n_swe = 0;
    if (mr && ma == 0 && r_swm) begin n_swm = 0; n_mre = 1; end
    if (sr && sa == 14) n_mwe = 0;
    if (sr && sa == 0 && r_mwm) begin n_mwm = 0; if (r_ack) ack_now = 1; end
    if (sw && sa == 15 && !sd[4] && !(mr && ma == 0 && r_swm)) n_mre = 0;
    if (slave_ok && sa == 0) n_swm = 1;
    if (slave_ok && sa == 14) begin n_swe = 1; if (r_ack) ack_now = 1; end
    if (master_takes) n_mwm = 1;
    if (master_ok && ma == 14) n_mwe = 1;
    if (mr || mw) n_rdy = 1;
    if (ack_now) n_rdy = 0;
    if (sw && sa == 15) begin r_ack = sd[6]; r_ien = sd[7]; end
    if (slave_ok) ref_mem[sa] = sd;
    if (master_ok) ref_mem[ma] = md;
    r_swm = n_swm; r_mwm = n_mwm; r_swe = n_swe; r_mwe = n_mwe; r_mre = n_mre; r_rdy = n_rdy;
  endtask

  task automatic step(bit mw, int ma, int md, bit mr, bit sw, int sa, int sd, bit sr);
    @(negedge clk);
    m_wr = mw; m_addr = 4'(ma); m_wdata = 8'(md); m_rd = mr;
    s_wr = sw; s_addr = 4'(sa); s_wdata = 8'(sd); s_rd = sr;
    #1;
    got_m = m_rdata; got_s = s_rdata;
    check(got_m == ref_read_m(ma), "R2 master read vs model", got_m, ref_read_m(ma));
    check(got_s == ref_read_s(sa), "R2 slave read vs model", got_s, ref_read_s(sa));
    ref_edge(mw, ma, md, mr, sw, sa, sd, sr);
    @(posedge clk); #1;
    check(ready_n == r_rdy, "R11 ready_n vs model", ready_n, r_rdy);
    check(irq == (r_mre && r_ien), "R7 irq vs model", irq, r_mre && r_ien);
  endtask

  task automatic idle();          step(0,0,0,0, 0,0,0,0); endtask
  task automatic mwr(int a, int d); step(1,a,d,0, 0,0,0,0); endtask
  task automatic mrd(int a);        step(0,a,0,1, 0,0,0,0); endtask
  task automatic swr(int a, int d); step(0,0,0,0, 1,a,d,0); endtask
  task automatic srd(int a);        step(0,0,0,0, 0,a,0,1); endtask

  task automatic expect_status(int exp, string tag);
    step(0,0,0,0, 0,15,0,0);
    check(got_s == exp, tag, got_s, exp);
  endtask

  initial begin
    #(200000 * 20);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    ref_reset();
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    step(0,7,0,0, 0,15,0,0);
    check(got_m == 0, "R1 cell after reset", got_m, 0);
    check(got_s == 0, "R1 status after reset", got_s, 0);
    check(ready_n == 1, "R1 ready_n after reset", ready_n, 1);
    check(irq == 0, "R1 irq after reset", irq, 0);

    swr(15, 8'hC0);
    expect_status(8'hC0, "R13 enable bits load");

    // slave to master
    swr(0, 8'h11);
    expect_status(8'hC1, "R3 slave claim");
    mwr(3, 8'hEE);
    mwr(0, 8'hEF);
    mrd(3);
    check(got_m == 0, "R4 master write dropped", got_m, 0);
    expect_status(8'hC1, "R4 master claim refused");
    for (int i = 1; i < 14; i++) swr(i, 8'h20 + i);
    swr(14, 8'h5A);
    check(ready_n == 0, "R5 ready_n low after end write", ready_n, 0);
    expect_status(8'hC5, "R5 slave end flag");
    mrd(14);
    check(got_m == 8'h5A, "R2 end byte read", got_m, 8'h5A);
    check(ready_n == 1, "R11 ready_n released by master read", ready_n, 1);
    expect_status(8'hC1, "R6 end flag cleared");
    for (int i = 1; i < 14; i++) begin
      mrd(i);
      check(got_m == 8'h20 + i, "R2 payload byte", got_m, 8'h20 + i);
    end
    mrd(0);
    check(got_m == 8'h11, "R2 claim byte", got_m, 8'h11);
    check(irq == 1, "R7 irq raised", irq, 1);
    expect_status(8'hD0, "R6 mode cleared read-end set");
    swr(15, 8'hD0);
    expect_status(8'hD0, "R13 bit4 one keeps read-end");
    swr(15, 8'hCF);
    check(irq == 0, "R7 irq dropped", irq, 0);
    expect_status(8'hC0, "R13 clear read-end, flags untouched");

    // master to slave
    mwr(0, 8'h77);
    expect_status(8'hC2, "R8 master claim");
    swr(2, 8'h99);
    mrd(2);
    check(got_m == 8'h22, "R8 slave write dropped", got_m, 8'h22);
    mwr(14, 8'h66);
    expect_status(8'hCA, "R9 master end flag");
    srd(14);
    check(got_s == 8'h66, "R2 slave reads end byte", got_s, 8'h66);
    expect_status(8'hC2, "R9 end flag cleared");
    srd(0);
    check(got_s == 8'h77, "R2 slave reads claim byte", got_s, 8'h77);
    check(ready_n == 0, "R10 receipt ack", ready_n, 0);
    expect_status(8'hC0, "R10 master mode cleared");
    idle();
    check(ready_n == 0, "R11 ready_n held without master access", ready_n, 0);
    mrd(5);
    check(ready_n == 1, "R11 ready_n released", ready_n, 1);

    // same-cycle claim
    step(1,0,8'hA1,0, 1,0,8'hB2,0);
    expect_status(8'hC2, "R12 master wins claim");
    mrd(0);
    check(got_m == 8'hA1, "R12 master byte kept", got_m, 8'hA1);
    srd(0);
    mwr(9, 8'h01);
    expect_status(8'hC0, "R12 released");

    // acknowledge and interrupt disabled
    swr(15, 8'h00);
    swr(0, 8'h33);
    swr(14, 8'h44);
    check(ready_n == 1, "R14 no ack when disabled", ready_n, 1);
    mrd(14);
    mrd(0);
    check(irq == 0, "R7 irq masked", irq, 0);
    expect_status(8'h10, "R6 read-end with masks off");
    swr(15, 8'h90);
    check(irq == 1, "R7 irq on enable", irq, 1);
    swr(15, 8'h00);
    check(irq == 0, "R13 read-end cleared", irq, 0);
    idle();

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule